// File: doc/BRIEF.md
# Multi-Channel Register Address Decoder with Broadcast Write

This block sits between a synchronous host register bus and a device built from eight identical channel register banks plus one small group of registers shared by all channels. It splits a 12-bit host address into a channel-select nibble and an 8-bit local offset. It drives per-bank write and read enables and the local offset. It also returns registered read data from the selected target.

Select values 0 to 7 reach one bank each. Select value 8 is a broadcast write: one host write lands at the same offset in every bank in the same clock. Two fixed addresses, 0x902 and 0x903, reach the shared group. The shared group cannot be reached through any channel select. Every other select value is dead space.

Each bank and the shared group are backed by a small register file. This storage exists so that the decoding can be observed at the bus.

Top module: `chanreg_decoder`

## Requirements
- R1: With host_addr[11:8] in 0..7, a write asserts only bank_wen[host_addr[11:8]] and updates only that bank. A read asserts only bank_ren[host_addr[11:8]]. bank_ren is never more than one-hot.
- R2: With host_addr[11:8] equal to 8, a write asserts all eight bank_wen bits in the same cycle and updates the same offset in every bank.
- R3: Addresses 0x902 and 0x903 read and write shared registers 0 and 1 and assert shared_hit. Such accesses touch no bank. No other address, including 0x002 or the broadcast address 0x802, reaches a shared register.
- R4: During and after synchronous active-high reset, every bank register reads 0xFF, both shared registers read 0x00, and host_rdata is 0x00.
- R5: host_rdata changes only on the clock edge where host_re is high, and then carries the value the target held before that edge. A write in the same cycle to the same register is not yet visible.
- R6: A read with host_addr[11:8] equal to 8 returns 0x00.
- R7: With host_addr[11:8] in 9..15, apart from 0x902 and 0x903, writes change no register and assert no enable, and reads return 0x00.
- R8: local_off always equals host_addr[7:0]. Each bank implements offsets 0..3. Writes to higher offsets change nothing, and reads from them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 12 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_we | input | 1 | Write enable |
| host_re | input | 1 | Read enable |
| host_rdata | output | 8 | Registered read data, one clock after host_re |
| bank_wen | output | 8 | Per-bank write enables |
| bank_ren | output | 8 | Per-bank read select |
| shared_hit | output | 1 | Access targets the shared group |
| local_off | output | 8 | Offset passed to the banks |

## Verification
Each bank is first given a distinct value, so a write that reached the wrong bank shows up on read-back. A broadcast write is then read back from all eight banks, which separates a true fan-out from a write to bank 0 only. Writes aimed at 0x002, 0x802 and the dead selects are followed by reads of the shared group and of the banks, so leakage into either is caught. A long random mix of select values, offsets and overlapping read and write enables then exercises the one-cycle read timing against old data and the hold behaviour when no read is issued.

// File: rtl/chanreg_pkg.sv
package chanreg_pkg;
    localparam int ADDR_W      = 12;
    localparam int DATA_W      = 8;
    localparam int OFF_W       = 8;
    localparam int SEL_W       = ADDR_W - OFF_W;
    localparam int NUM_BANKS   = 8;
    localparam int BANK_IDX_W  = $clog2(NUM_BANKS);
    localparam int SHARED_REGS = 2;

    localparam logic [SEL_W-1:0]  BCAST_SEL   = SEL_W'(NUM_BANKS);
    localparam logic [ADDR_W-1:0] SHARED_BASE = 12'h902;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_BANK,
        TGT_BCAST,
        TGT_SHARED
    } tgt_e;

    typedef struct packed {
        tgt_e             kind;
        logic [SEL_W-1:0] sel;
        logic [OFF_W-1:0] off;
    } dec_t;

    function automatic logic is_shared(input logic [ADDR_W-1:0] a);
        return (a >= SHARED_BASE) && (a < SHARED_BASE + ADDR_W'(SHARED_REGS));
    endfunction

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.sel = a[ADDR_W-1:OFF_W];
        d.off = a[OFF_W-1:0];
        if (is_shared(a))
            d.kind = TGT_SHARED;
        else if (d.sel < SEL_W'(NUM_BANKS))
            d.kind = TGT_BANK;
        else if (d.sel == BCAST_SEL)
            d.kind = TGT_BCAST;
        else
            d.kind = TGT_NONE;
        return d;
    endfunction
endpackage

// File: rtl/chanreg_addr_decode.sv
module chanreg_addr_decode
    import chanreg_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 we,
    input  logic                 re,
    output dec_t                 dec,
    output logic [NUM_BANKS-1:0] bank_wen,
    output logic [NUM_BANKS-1:0] bank_ren,
    output logic                 shared_we,
    output logic                 shared_hit
);
    assign dec = decode(addr);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_en
        logic own;
        assign own         = (dec.kind == TGT_BANK) && (dec.sel == SEL_W'(b));
        assign bank_wen[b] = we && (own || dec.kind == TGT_BCAST);
        assign bank_ren[b] = re && own;
    end

    assign shared_we  = we && (dec.kind == TGT_SHARED);
    assign shared_hit = (we || re) && (dec.kind == TGT_SHARED);
endmodule

// File: rtl/chanreg_store.sv
module chanreg_store
    import chanreg_pkg::*;
#(
    parameter int                DEPTH   = 4,
    parameter logic [DATA_W-1:0] RST_VAL = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wen,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_val
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] regs [DEPTH];
    logic              in_range;
    logic [IDX_W-1:0]  idx;

    assign in_range = off < OFF_W'(DEPTH);
    assign idx      = off[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= RST_VAL;
        end else if (wen && in_range) begin
            regs[idx] <= wdata;
        end
    end

    assign rd_val = in_range ? regs[idx] : '0;
endmodule

// File: rtl/chanreg_decoder.sv
module chanreg_decoder
    import chanreg_pkg::*;
#(
    parameter int                BANK_REGS  = 4,
    parameter logic [DATA_W-1:0] BANK_RST   = 8'hFF,
    parameter logic [DATA_W-1:0] SHARED_RST = 8'h00
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [DATA_W-1:0]    host_wdata,
    input  logic                 host_we,
    input  logic                 host_re,
    output logic [DATA_W-1:0]    host_rdata,
    output logic [NUM_BANKS-1:0] bank_wen,
    output logic [NUM_BANKS-1:0] bank_ren,
    output logic                 shared_hit,
    output logic [OFF_W-1:0]     local_off
);
    dec_t              dec;
    logic              shared_we;
    logic [OFF_W-1:0]  shared_off;
    logic [DATA_W-1:0] bank_rd [NUM_BANKS];
    logic [DATA_W-1:0] shared_rd;
    logic [DATA_W-1:0] rd_next;

    chanreg_addr_decode u_dec (
        .addr       (host_addr),
        .we         (host_we),
        .re         (host_re),
        .dec        (dec),
        .bank_wen   (bank_wen),
        .bank_ren   (bank_ren),
        .shared_we  (shared_we),
        .shared_hit (shared_hit)
    );

    assign local_off  = dec.off;
    assign shared_off = dec.off - SHARED_BASE[OFF_W-1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        chanreg_store #(.DEPTH(BANK_REGS), .RST_VAL(BANK_RST)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .wen    (bank_wen[b]),
            .off    (local_off),
            .wdata  (host_wdata),
            .rd_val (bank_rd[b])
        );
    end

    chanreg_store #(.DEPTH(SHARED_REGS), .RST_VAL(SHARED_RST)) u_shared (
        .clk    (clk),
        .rst    (rst),
        .wen    (shared_we),
        .off    (shared_off),
        .wdata  (host_wdata),
        .rd_val (shared_rd)
    );

    always_comb begin
        unique case (dec.kind)
            TGT_BANK:   rd_next = bank_rd[dec.sel[BANK_IDX_W-1:0]];
            TGT_SHARED: rd_next = shared_rd;
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            host_rdata <= '0;
        else if (host_re)
            host_rdata <= rd_next;
    end
endmodule

// File: rtl/chanreg_decoder_chk.sv
module chanreg_decoder_chk
    import chanreg_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    host_addr,
    input logic                 host_we,
    input logic                 host_re,
    input logic [DATA_W-1:0]    host_rdata,
    input logic [NUM_BANKS-1:0] bank_wen,
    input logic [NUM_BANKS-1:0] bank_ren,
    input logic                 shared_hit
);
    logic [SEL_W-1:0] sel;
    logic             shr;
    assign sel = host_addr[ADDR_W-1:OFF_W];
    assign shr = (host_addr == SHARED_BASE) || (host_addr == SHARED_BASE + 12'd1);

    // R1
    ren_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_ren));

    // R2
    bcast_all_chk: assert property (@(posedge clk) disable iff (rst)
        (host_we && sel == BCAST_SEL) |-> (&bank_wen));

    // R3
    shared_isolated_chk: assert property (@(posedge clk) disable iff (rst)
        shared_hit |-> (bank_wen == '0 && bank_ren == '0));

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !host_re |=> $stable(host_rdata));

    // R6
    bcast_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (host_re && sel == BCAST_SEL) |=> (host_rdata == '0));

    // R7
    dead_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (sel > BCAST_SEL && !shr) |-> (bank_wen == '0 && bank_ren == '0 && !shared_hit));
endmodule

bind chanreg_decoder chanreg_decoder_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_we    (host_we),
    .host_re    (host_re),
    .host_rdata (host_rdata),
    .bank_wen   (bank_wen),
    .bank_ren   (bank_ren),
    .shared_hit (shared_hit)
);

// File: tb/chanreg_decoder_tb.sv
`timescale 1ns/1ps
module chanreg_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_we = 1'b0;
    logic        host_re = 1'b0;
    logic [7:0]  host_rdata;
    logic [7:0]  bank_wen;
    logic [7:0]  bank_ren;
    logic        shared_hit;
    logic [7:0]  local_off;

    always #10 clk = ~clk;

    chanreg_decoder dut_i (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_we    (host_we),
        .host_re    (host_re),
        .host_rdata (host_rdata),
        .bank_wen   (bank_wen),
        .bank_ren   (bank_ren),
        .shared_hit (shared_hit),
        .local_off  (local_off)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model
    logic [7:0] m_bank [8][4];
    logic [7:0] m_sh [2];
    logic [7:0] exp_rd;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit m_shared(logic [11:0] a);
        return a == 12'h902 || a == 12'h903;
    endfunction

    function automatic string cls_tag(logic [11:0] a);
        int s = int'(a[11:8]);
        if (m_shared(a)) return "R3";
        if (s < 8) return "R1";
        if (s == 8) return "R2";
        return "R7";
    endfunction

    function automatic logic [7:0] m_read(logic [11:0] a);
        int s = int'(a[11:8]);
        int o = int'(a[7:0]);
        if (m_shared(a)) return m_sh[o - 2];
        if (s < 8 && o < 4) return m_bank[s][o];
        return 8'h00;
    endfunction

    task automatic m_reset();
        for (int b = 0; b < 8; b++)
            for (int o = 0; o < 4; o++) m_bank[b][o] = 8'hFF;
        m_sh[0] = 8'h00;
        m_sh[1] = 8'h00;
        exp_rd  = 8'h00;
    endtask

    task automatic cyc(logic [11:0] a, logic [7:0] wd, logic we, logic re, string rtag = "");
        int s = int'(a[11:8]);
        int o = int'(a[7:0]);
        logic [7:0] e_wen;
        logic [7:0] e_ren;
        string t;
        host_addr  = a;
        host_wdata = wd;
        host_we    = we;
        host_re    = re;
        #1;
        e_wen = 8'h00;
        e_ren = 8'h00;
        if (!m_shared(a) && s < 8) begin
            if (we) e_wen = 8'(1 << s);
            if (re) e_ren = 8'(1 << s);
        end else if (s == 8 && we) begin
            e_wen = 8'hFF;
        end
        chk(cls_tag(a), "bank_wen", 32'(bank_wen), 32'(e_wen));
        chk(cls_tag(a), "bank_ren", 32'(bank_ren), 32'(e_ren));
        chk("R3", "shared_hit", 32'(shared_hit), 32'((we || re) && m_shared(a)));
        chk("R8", "local_off", 32'(local_off), 32'(a[7:0]));
        @(posedge clk);
        if (re) exp_rd = m_read(a);
        if (we) begin
            if (m_shared(a)) m_sh[o - 2] = wd;
            else if (s < 8 && o < 4) m_bank[s][o] = wd;
            else if (s == 8 && o < 4)
                for (int b = 0; b < 8; b++) m_bank[b][o] = wd;
        end
        @(negedge clk);
        if (rtag != "") t = rtag;
        else if (!re) t = "R5";
        else if (m_shared(a)) t = "R3";
        else if (s == 8) t = "R6";
        else if (s > 8) t = "R7";
        else if (o >= 4) t = "R8";
        else t = "R5";
        chk(t, "host_rdata", 32'(host_rdata), 32'(exp_rd));
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        chk("R4", "host_rdata in reset", 32'(host_rdata), 32'h0);
        rst = 1'b0;

        // R4: reset values everywhere
        for (int b = 0; b < 8; b++)
            for (int o = 0; o < 4; o++) cyc(12'((b << 8) | o), 8'h00, 1'b0, 1'b1, "R4");
        cyc(12'h902, 8'h00, 1'b0, 1'b1, "R4");
        cyc(12'h903, 8'h00, 1'b0, 1'b1, "R4");

        // R1: distinct value per bank, then read back
        for (int b = 0; b < 8; b++)
            for (int o = 0; o < 4; o++) cyc(12'((b << 8) | o), 8'((b << 4) | o), 1'b1, 1'b0);
        for (int b = 0; b < 8; b++)
            for (int o = 0; o < 4; o++) cyc(12'((b << 8) | o), 8'h00, 1'b0, 1'b1, "R1");

        // R2: broadcast write and read-back from all banks; R6: broadcast read
        cyc(12'h802, 8'hA5, 1'b1, 1'b0);
        for (int b = 0; b < 8; b++) cyc(12'((b << 8) | 2), 8'h00, 1'b0, 1'b1, "R2");
        cyc(12'h802, 8'h00, 1'b0, 1'b1);

        // R3: shared registers and leakage attempts
        cyc(12'h902, 8'h3C, 1'b1, 1'b0);
        cyc(12'h903, 8'hC3, 1'b1, 1'b0);
        cyc(12'h002, 8'h11, 1'b1, 1'b0);
        cyc(12'h803, 8'h22, 1'b1, 1'b0);
        cyc(12'hA02, 8'h33, 1'b1, 1'b0);
        cyc(12'h902, 8'h00, 1'b0, 1'b1);
        cyc(12'h903, 8'h00, 1'b0, 1'b1);
        cyc(12'h902, 8'h00, 1'b0, 1'b1, "R3");

        // R7: dead selects
        for (int s = 9; s < 16; s++) begin
            cyc(12'((s << 8) | 1), 8'h5A, 1'b1, 1'b0);
            cyc(12'((s << 8) | 1), 8'h00, 1'b0, 1'b1);
        end
        cyc(12'h901, 8'h00, 1'b0, 1'b1);
        for (int b = 0; b < 8; b++) cyc(12'((b << 8) | 1), 8'h00, 1'b0, 1'b1, "R7");

        // R8: out-of-range offsets
        cyc(12'h305, 8'h77, 1'b1, 1'b0);
        cyc(12'h305, 8'h00, 1'b0, 1'b1);
        cyc(12'h8F0, 8'h66, 1'b1, 1'b0);
        for (int b = 0; b < 8; b++) cyc(12'((b << 8) | 3), 8'h00, 1'b0, 1'b1, "R8");

        // R5: read and write together, then hold
        cyc(12'h401, 8'hE1, 1'b1, 1'b1);
        cyc(12'h000, 8'h00, 1'b0, 1'b0);
        cyc(12'h401, 8'h00, 1'b0, 1'b1);
        cyc(12'h902, 8'h9E, 1'b1, 1'b1);
        cyc(12'h902, 8'h00, 1'b0, 1'b0);

        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            logic [11:0] a;
            if ($urandom % 10 == 0) a = 12'h902 + 12'($urandom % 2);
            else a = 12'((($urandom % 16) << 8) | ($urandom % 6));
            cyc(a, 8'($urandom), 1'($urandom % 2), 1'($urandom % 2));
        end

        summary();
    end
endmodule